// File: doc/BRIEF.md
# Queued SPI Command Sequencer

This block steps through a ring of sixteen command slots and hands one transfer at a time to an SPI master engine. Software sets a first-slot index and a last-slot index, picks whether the run stops at the last slot or loops, and then pulses a trigger. For every slot the sequencer puts the slot index on a lookup port, drives the chip-select lines with the pattern read back for that slot, strobes the engine and waits for the engine's completion handshake.

When a slot completes, the block records that slot's index as the completed index and moves on. After the last slot it either stops or loops back. The loop target is selectable: slot zero, or the first slot. A halt request lets the slot in flight complete and then ends the run. Each stop raises a one-cycle finish pulse and a sticky finish flag. While no slot is running, the chip-select lines rest at a programmable idle level.

Top module: `spi_queue_seq`

## Requirements
- R1: After reset `busy`, `xferStart`, `donePulse` and `doneFlag` are 0, `cptPtr` is 0 and every bit of `csOut` is 0.
- R2: A `go` pulse while idle starts a run. In the next cycle `busy` and `xferStart` are 1, and `cmdIdx` equals `startPtr`.
- R3: `xferStart` is high for exactly one cycle per slot. The next slot is not issued until `xferDone` has been seen for the current slot.
- R4: In the cycle after `xferDone` is sampled, `cptPtr` holds the index of the slot that just completed. `cptPtr` holds its value at all other times.
- R5: With `wrapEn`=0, the run ends after the slot at `endPtr` completes. In the cycle `busy` falls, `donePulse` is 1 for one cycle and `doneFlag` becomes 1. `doneFlag` stays 1 until the next accepted `go` clears it.
- R6: Slot indices advance by one modulo 16. An `endPtr` below `startPtr` forms a run that passes from 15 to 0.
- R7: With `wrapEn`=1 and `wrapToStart`=0, the slot after `endPtr` is slot 0.
- R8: With `wrapEn`=1 and `wrapToStart`=1, the slot after `endPtr` is the slot at `startPtr`.
- R9: If `halt` is high at any time during a run, the slot in flight completes and no further slot is issued. The run then ends with `donePulse` and `doneFlag` as in R5.
- R10: While `busy`, `csOut` equals `cmdCs`. While idle, every bit of `csOut` equals the value `csIdle` had one cycle earlier: 0 gives active-high selects, 1 gives active-low selects.
- R11: A `go` pulse while `busy` does not change the slot order of the run in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| go | input | 1 | Run trigger pulse |
| startPtr | input | 4 | First slot index |
| endPtr | input | 4 | Last slot index |
| wrapEn | input | 1 | Loop after the last slot |
| wrapToStart | input | 1 | Loop target: 0 = slot zero, 1 = first slot |
| halt | input | 1 | Stop after the slot in flight |
| csIdle | input | 1 | Chip-select idle level |
| cmdIdx | output | 4 | Index of the slot being executed |
| cmdCs | input | 4 | Chip-select pattern of slot `cmdIdx` |
| xferStart | output | 1 | One-cycle start strobe to the SPI engine |
| xferDone | input | 1 | Engine completion handshake |
| csOut | output | 4 | Chip-select lines |
| busy | output | 1 | Run in progress |
| cptPtr | output | 4 | Index of the last completed slot |
| donePulse | output | 1 | One-cycle finish pulse |
| doneFlag | output | 1 | Sticky finish flag |

## Verification
Runs are tried with five patterns:
- A plain ascending range, which separates correct stopping at the last slot from running past it.
- A range whose last index lies below its first, which shows the modulo-16 step through 15 to 0.
- Looping to slot zero and looping to the first slot, run against each other. A loop target wired the wrong way reorders the expected slots.
- A halt raised in the middle of a non-looping range, which shows the in-flight slot completing and nothing issued after it.

A second trigger during a run, and an active-low idle level, are layered onto one of these runs.

// File: rtl/spiq_pkg.sv
package spiq_pkg;
  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} seqState_t;

  typedef struct packed {
    logic loadStart;
    logic step;
    logic wrapJump;
    logic commit;
    logic finish;
  } seqCtl_t;
endpackage

// File: rtl/spiq_ctrl.sv
module spiq_ctrl
  import spiq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    go,
  input  logic    xferDone,
  input  logic    atEnd,
  input  logic    stopReq,
  input  logic    wrapEn,
  output seqCtl_t ctl,
  output logic    busy,
  output logic    xferStart
);
  seqState_t stateQ, stateD;

  always_comb begin
    ctl    = '0;
    stateD = stateQ;
    case (stateQ)
      S_IDLE: begin
        if (go) begin
          ctl.loadStart = 1'b1;
          stateD        = S_ISSUE;
        end
      end
      S_ISSUE: stateD = S_WAIT;
      S_WAIT: begin
        if (xferDone) begin
          ctl.commit = 1'b1;
          if (stopReq) begin
            ctl.finish = 1'b1;
            stateD     = S_IDLE;
          end else if (atEnd) begin
            if (wrapEn) begin
              ctl.wrapJump = 1'b1;
              stateD       = S_ISSUE;
            end else begin
              ctl.finish = 1'b1;
              stateD     = S_IDLE;
            end
          end else begin
            ctl.step = 1'b1;
            stateD   = S_ISSUE;
          end
        end
      end
      default: stateD = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= S_IDLE;
    else       stateQ <= stateD;
  end

  assign busy      = (stateQ != S_IDLE);
  assign xferStart = (stateQ == S_ISSUE);

  // R3: the strobe never lasts two cycles
  a_r3_one_shot: assert property (@(posedge clk) disable iff (!rstN)
    xferStart |=> !xferStart);
  // R3: no new slot while waiting for the handshake
  a_r3_wait_hold: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == S_WAIT && !xferDone) |=> (stateQ == S_WAIT));
endmodule

// File: rtl/spiq_datapath.sv
module spiq_datapath
  import spiq_pkg::*;
#(
  parameter int QDEPTH = 16,
  parameter int NCS    = 4,
  localparam int PW    = $clog2(QDEPTH)
) (
  input  logic          clk,
  input  logic          rstN,
  input  seqCtl_t       ctl,
  input  logic          busy,
  input  logic [PW-1:0] startPtr,
  input  logic [PW-1:0] endPtr,
  input  logic          wrapToStart,
  input  logic          halt,
  input  logic          csIdle,
  input  logic [NCS-1:0] cmdCs,
  output logic [PW-1:0] curPtr,
  output logic [PW-1:0] cptPtr,
  output logic          atEnd,
  output logic          stopReq,
  output logic [NCS-1:0] csOut,
  output logic          donePulse,
  output logic          doneFlag
);
  localparam logic [PW-1:0] LAST = PW'(QDEPTH - 1);

  logic          haltPend;
  logic          csIdleQ;
  logic [PW-1:0] nextSeq;

  assign nextSeq = (curPtr == LAST) ? '0 : curPtr + 1'b1;
  assign atEnd   = (curPtr == endPtr);
  assign stopReq = haltPend | halt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curPtr    <= '0;
      cptPtr    <= '0;
      haltPend  <= 1'b0;
      csIdleQ   <= 1'b0;
      donePulse <= 1'b0;
      doneFlag  <= 1'b0;
    end else begin
      csIdleQ   <= csIdle;
      donePulse <= ctl.finish;
      if (ctl.loadStart)     curPtr <= startPtr;
      else if (ctl.wrapJump) curPtr <= wrapToStart ? startPtr : '0;
      else if (ctl.step)     curPtr <= nextSeq;
      if (ctl.commit) cptPtr <= curPtr;
      if (ctl.finish)          haltPend <= 1'b0;
      else if (halt && busy)   haltPend <= 1'b1;
      if (ctl.loadStart)   doneFlag <= 1'b0;
      else if (ctl.finish) doneFlag <= 1'b1;
    end
  end

  assign csOut = busy ? cmdCs : {NCS{csIdleQ}};

  // R4: completed index only moves on a completion
  a_r4_cpt_hold: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.commit |=> $stable(cptPtr));
  // R5: finish flag is sticky until a new run
  a_r5_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (doneFlag && !ctl.loadStart) |=> doneFlag);
endmodule

// File: rtl/spi_queue_seq.sv
module spi_queue_seq
  import spiq_pkg::*;
#(
  parameter int QDEPTH = 16,
  parameter int NCS    = 4,
  localparam int PW    = $clog2(QDEPTH)
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           go,
  input  logic [PW-1:0]  startPtr,
  input  logic [PW-1:0]  endPtr,
  input  logic           wrapEn,
  input  logic           wrapToStart,
  input  logic           halt,
  input  logic           csIdle,
  output logic [PW-1:0]  cmdIdx,
  input  logic [NCS-1:0] cmdCs,
  output logic           xferStart,
  input  logic           xferDone,
  output logic [NCS-1:0] csOut,
  output logic           busy,
  output logic [PW-1:0]  cptPtr,
  output logic           donePulse,
  output logic           doneFlag
);
  seqCtl_t ctl;
  logic    atEnd;
  logic    stopReq;

  spiq_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .go(go), .xferDone(xferDone),
    .atEnd(atEnd), .stopReq(stopReq), .wrapEn(wrapEn),
    .ctl(ctl), .busy(busy), .xferStart(xferStart)
  );

  spiq_datapath #(.QDEPTH(QDEPTH), .NCS(NCS)) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .busy(busy),
    .startPtr(startPtr), .endPtr(endPtr), .wrapToStart(wrapToStart),
    .halt(halt), .csIdle(csIdle), .cmdCs(cmdCs),
    .curPtr(cmdIdx), .cptPtr(cptPtr), .atEnd(atEnd), .stopReq(stopReq),
    .csOut(csOut), .donePulse(donePulse), .doneFlag(doneFlag)
  );

  // R2: accepted trigger issues the first slot next cycle
  a_r2_launch: assert property (@(posedge clk) disable iff (!rstN)
    (go && !busy) |=> (xferStart && busy && cmdIdx == $past(startPtr)));
  // R10: selects follow the slot pattern while running
  a_r10_cs_busy: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (csOut == cmdCs));
  // R5: finish pulse only when stopped with the flag set
  a_r5_pulse_idle: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |-> (!busy && doneFlag));
endmodule

// File: tb/spi_queue_seq_tb_top.sv
module spi_queue_seq_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       go = 1'b0;
  logic [3:0] startPtr = '0;
  logic [3:0] endPtr = '0;
  logic       wrapEn = 1'b0;
  logic       wrapToStart = 1'b0;
  logic       halt = 1'b0;
  logic       csIdle = 1'b0;
  logic [3:0] cmdIdx;
  logic [3:0] cmdCs;
  logic       xferStart;
  logic       xferDone = 1'b0;
  logic [3:0] csOut;
  logic       busy;
  logic [3:0] cptPtr;
  logic       donePulse;
  logic       doneFlag;

  int nChecks = 0;
  int nFails  = 0;
  int svc = 0;
  int haltAfter = 0;
  string curTag = "R2";
  int expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  // slot pattern lookup, a fixed function of the index
  assign cmdCs = cmdIdx ^ 4'b0110;

  spi_queue_seq dut_i (
    .clk(clk), .rstN(rstN), .go(go), .startPtr(startPtr), .endPtr(endPtr),
    .wrapEn(wrapEn), .wrapToStart(wrapToStart), .halt(halt), .csIdle(csIdle),
    .cmdIdx(cmdIdx), .cmdCs(cmdCs), .xferStart(xferStart), .xferDone(xferDone),
    .csOut(csOut), .busy(busy), .cptPtr(cptPtr), .donePulse(donePulse),
    .doneFlag(doneFlag)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor + engine stub: pops expected slots as the design issues them
  initial begin
    forever begin
      @(negedge clk);
      while (xferStart) begin
        int e;
        svc++;
        e = -1;
        if (expQ.size() == 0) check(1'b0, {curTag, " unexpected slot"}, cmdIdx, -1);
        else begin
          e = expQ.pop_front();
          check(cmdIdx == 4'(e), {curTag, " slot order"}, cmdIdx, e);
        end
        if (svc == haltAfter) halt = 1'b1;
        @(negedge clk);
        check(!xferStart, "R3 strobe width", xferStart, 0);
        check(csOut == cmdCs, "R10 active pattern", csOut, cmdCs);
        @(negedge clk);
        check(busy && !xferStart, "R3 waits for done", xferStart, 0);
        xferDone = 1'b1;
        @(negedge clk);
        xferDone = 1'b0;
        halt = 1'b0;
        if (e >= 0) check(cptPtr == 4'(e), "R4 completed index", cptPtr, e);
      end
    end
  end

  // driver: computes the expected slot sequence and launches the run
  task automatic runQueue(input int s, input int en, input bit we, input bit wts,
                          input int hAfter, input string tag, input bit extraGo);
    int idx;
    int n;
    idx = s;
    n = 0;
    curTag = tag;
    svc = 0;
    haltAfter = hAfter;
    forever begin
      expQ.push_back(idx);
      n++;
      if (n == hAfter) break;
      if (idx == en && !we) break;
      if (idx == en) idx = wts ? s : 0;
      else idx = (idx + 1) % 16;
    end
    startPtr = 4'(s); endPtr = 4'(en); wrapEn = we; wrapToStart = wts;
    @(negedge clk);
    go = 1'b1;
    @(negedge clk);
    go = 1'b0;
    check(busy && !doneFlag, "R5 flag cleared by go", doneFlag, 0);
    if (extraGo) begin
      @(negedge clk);
      @(negedge clk);
      go = 1'b1;
      @(negedge clk);
      go = 1'b0;
    end
    begin
      int guard;
      guard = 0;
      while (busy && guard < 2000) begin
        @(negedge clk);
        guard++;
      end
    end
    check(!busy, {tag, " run ends"}, busy, 0);
    check(donePulse, {tag, " R5 finish pulse"}, donePulse, 1);
    check(expQ.size() == 0, {tag, " all slots run"}, expQ.size(), 0);
    @(negedge clk);
    check(!donePulse && doneFlag, "R5 pulse one cycle, flag sticky", donePulse, 0);
    repeat (3) @(negedge clk);
    check(!busy && !xferStart, {tag, " stays stopped"}, busy, 0);
    check(csOut == {4{csIdle}}, "R10 idle level", csOut, {4{csIdle}});
    check(doneFlag, "R5 flag held", doneFlag, 1);
    expQ.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!busy && !xferStart, "R1 idle", busy, 0);
    check(cptPtr == 0, "R1 cptPtr", cptPtr, 0);
    check(csOut == 4'h0, "R1 csOut", csOut, 0);
    check(!donePulse && !doneFlag, "R1 done", doneFlag, 0);

    runQueue(2, 5, 1'b0, 1'b0, 0, "R5", 1'b0);
    check(cptPtr == 5, "R5 last index", cptPtr, 5);
    csIdle = 1'b1;
    runQueue(13, 2, 1'b0, 1'b0, 0, "R6 R11", 1'b1);
    check(csOut == 4'hF, "R10 active-low idle", csOut, 15);
    csIdle = 1'b0;
    runQueue(6, 8, 1'b1, 1'b0, 7, "R7", 1'b0);
    check(cptPtr == 3, "R7 last index", cptPtr, 3);
    runQueue(10, 11, 1'b1, 1'b1, 5, "R8", 1'b0);
    check(cptPtr == 10, "R8 last index", cptPtr, 10);
    runQueue(0, 9, 1'b0, 1'b0, 2, "R9", 1'b0);
    check(cptPtr == 1, "R9 halted index", cptPtr, 1);
    check(csOut == 4'h0, "R10 active-high idle", csOut, 0);

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule